// File: doc/BRIEF.md
# Transmit In-Band Port Demultiplexer

This block sits on the transmit side of a 32-bit packet bus that four ports share. There are no per-port select lines. The sender picks a port with an address cycle: the start strobe is high, the enable is low, and the low data bits carry the port number. Every data cycle after that is delivered to the port that was addressed most recently. A data cycle has the strobe low and the enable high. Each delivered word reaches its lane with a byte-valid mask and start and end markers.

Every word of a packet except the last carries four bytes. The last word is flagged by an end-of-packet input, and a 2-bit modifier gives its byte count. Start-of-packet is tracked per port, so packets to different ports may interleave at word granularity. The block also reports protocol errors: a cycle with the strobe and the enable both high, and a non-final word that carries a nonzero modifier.

All outputs are registered. A word sampled at one clock edge appears on its lane after that edge.

Top module: `tx_inband_demux`

## Requirements
- R1: Reset clears all lane valids, markers, masks, data and error flags, and sets the current port to 0.
- R2: An address cycle (start=1, enable=0) loads the current port from data bits [1:0], ignoring all higher bits. It produces no lane output. The new port is visible on o_port after that edge.
- R3: A data cycle (start=0, enable=1) raises exactly one lane valid for one cycle, on the lane of the current port. That lane's data output equals the sampled word.
- R4: An idle cycle (start=0, enable=0) raises no lane valid and no error flag, whatever the other inputs are.
- R5: A cycle with start=1 and enable=1 pulses o_clash for one cycle. Its data is discarded, no lane valid rises, and the current port does not change.
- R6: On a word with end-of-packet set, the 4-bit mask gives the valid bytes, packed from the top. Mask bit 3 covers data bits [31:24] and bit 0 covers bits [7:0]. Modifier 0 gives 1111, 1 gives 1000, 2 gives 1100 and 3 gives 1110.
- R7: On a data word without end-of-packet, the mask is 1111 whatever the modifier is. A nonzero modifier on such a word pulses o_mod_warn together with the word.
- R8: The start marker is set on a data word when its port has no open packet, that is, after reset or after that port's last end-of-packet word. Each port keeps its own packet state across address cycles to other ports.
- R9: Data cycles that arrive before any address cycle after reset go to port 0.
- R10: The end marker on a lane follows the end-of-packet input of the delivered word. On cycles that are not data cycles, the end-of-packet input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_data | input | 32 | Shared bus word: port number in an address cycle, packet bytes in a data cycle |
| i_start | input | 1 | Start-of-transfer strobe; marks an address cycle |
| i_enable | input | 1 | Enable; marks a data cycle |
| i_eop | input | 1 | Last word of a packet |
| i_mod | input | 2 | Byte count of the last word (0 means four) |
| o_vld | output | 4 | Per-lane word valid |
| o_data | output | 128 | Per-lane word; lane p is bits [32p+31:32p] |
| o_bmask | output | 16 | Per-lane byte mask; lane p is bits [4p+3:4p] |
| o_sop | output | 4 | Per-lane start-of-packet marker |
| o_eop | output | 4 | Per-lane end-of-packet marker |
| o_clash | output | 1 | Strobe and enable were both high |
| o_mod_warn | output | 1 | Nonzero modifier on a non-final word |
| o_port | output | 2 | Currently addressed port |

## Verification
The hardest case to reach is per-port packet state under interleaving. A port must keep an open packet while other ports are addressed and fed, and then resume without a second start marker. Uniform random stimulus rarely returns to a port with its packet still open. The random generator therefore uses a low end-of-packet rate and frequent address cycles, so that several ports hold open packets at once. A directed sequence also splits one packet on port 1 around a full packet on port 3.

// File: rtl/tx_demux_pkg.sv
package tx_demux_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_ADDR  = 2'd1,
    CYC_DATA  = 2'd2,
    CYC_CLASH = 2'd3
  } cyc_kind_e;

  function automatic cyc_kind_e classify_cycle(input logic start, input logic enable);
    cyc_kind_e k;
    unique case ({start, enable})
      2'b10:   k = CYC_ADDR;
      2'b01:   k = CYC_DATA;
      2'b11:   k = CYC_CLASH;
      default: k = CYC_IDLE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/tx_cycle_decode.sv
module tx_cycle_decode
  import tx_demux_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 2
) (
  input  logic [DW-1:0]     data,
  input  logic              start,
  input  logic              enable,
  output cyc_kind_e         kind,
  output logic              is_addr,
  output logic              is_data,
  output logic              is_clash,
  output logic [ADDR_W-1:0] addr_port
);

  always_comb begin
    kind      = classify_cycle(start, enable);
    is_addr   = (kind == CYC_ADDR);
    is_data   = (kind == CYC_DATA);
    is_clash  = (kind == CYC_CLASH);
    addr_port = data[ADDR_W-1:0];
  end

endmodule

// File: rtl/tx_port_track.sv
module tx_port_track #(
  parameter int NPORT  = 4,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_addr,
  input  logic [ADDR_W-1:0] addr_port,
  input  logic              is_data,
  input  logic              eop,
  output logic [ADDR_W-1:0] cur_port,
  output logic              first_word
);

  logic [NPORT-1:0] open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_port <= '0;
    end else if (is_addr) begin
      cur_port <= addr_port;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_open
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q[p] <= 1'b0;
      end else if (is_data && (cur_port == ADDR_W'(p))) begin
        open_q[p] <= !eop;
      end
    end
  end

  always_comb first_word = !open_q[cur_port];

  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !is_addr |=> $stable(cur_port)); // R2

  AST_PORT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    is_addr |=> (cur_port == $past(addr_port))); // R2

endmodule

// File: rtl/tx_lane_steer.sv
module tx_lane_steer #(
  parameter int NPORT  = 4,
  parameter int DW     = 32,
  parameter int ADDR_W = 2,
  parameter int BYTES  = DW / 8,
  parameter int MOD_W  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   is_data,
  input  logic                   is_clash,
  input  logic [ADDR_W-1:0]      cur_port,
  input  logic                   first_word,
  input  logic                   eop,
  input  logic [MOD_W-1:0]       mod,
  input  logic [DW-1:0]          data,
  output logic [NPORT-1:0]       o_vld,
  output logic [NPORT*DW-1:0]    o_data,
  output logic [NPORT*BYTES-1:0] o_bmask,
  output logic [NPORT-1:0]       o_sop,
  output logic [NPORT-1:0]       o_eop,
  output logic                   o_clash,
  output logic                   o_mod_warn
);

  localparam logic [BYTES-1:0] ALL_ONES = '1;

  function automatic int mod_count(input logic [MOD_W-1:0] m);
    return (m == '0) ? BYTES : int'(m);
  endfunction

  function automatic logic [BYTES-1:0] tail_mask(input logic [MOD_W-1:0] m);
    return ~(ALL_ONES >> mod_count(m));
  endfunction

  logic [BYTES-1:0] word_mask;
  logic             warn_now;

  always_comb begin
    word_mask = eop ? tail_mask(mod) : ALL_ONES;
    warn_now  = is_data && !eop && (mod != '0);
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_lane
    logic hit;
    always_comb hit = is_data && (cur_port == ADDR_W'(p));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        o_vld[p]                   <= 1'b0;
        o_sop[p]                   <= 1'b0;
        o_eop[p]                   <= 1'b0;
        o_data[p*DW +: DW]         <= '0;
        o_bmask[p*BYTES +: BYTES]  <= '0;
      end else begin
        o_vld[p] <= hit;
        o_sop[p] <= hit && first_word;
        o_eop[p] <= hit && eop;
        if (hit) begin
          o_data[p*DW +: DW]        <= data;
          o_bmask[p*BYTES +: BYTES] <= word_mask;
        end
      end
    end

    AST_FULL_MID: assert property (@(posedge clk) disable iff (!rst_n)
      (o_vld[p] && !o_eop[p]) |-> (o_bmask[p*BYTES +: BYTES] == ALL_ONES)); // R7

    AST_MARK_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      (o_sop[p] || o_eop[p]) |-> o_vld[p]); // R8
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_clash    <= 1'b0;
      o_mod_warn <= 1'b0;
    end else begin
      o_clash    <= is_clash;
      o_mod_warn <= warn_now;
    end
  end

  AST_WARN_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    o_mod_warn |-> (($countones(o_vld) == 1) && (o_eop == '0))); // R7

endmodule

// File: rtl/tx_inband_demux.sv
module tx_inband_demux
  import tx_demux_pkg::*;
#(
  parameter int NPORT  = 4,
  parameter int DW     = 32,
  parameter int MOD_W  = 2,
  localparam int BYTES  = DW / 8,
  localparam int ADDR_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DW-1:0]          i_data,
  input  logic                   i_start,
  input  logic                   i_enable,
  input  logic                   i_eop,
  input  logic [MOD_W-1:0]       i_mod,
  output logic [NPORT-1:0]       o_vld,
  output logic [NPORT*DW-1:0]    o_data,
  output logic [NPORT*BYTES-1:0] o_bmask,
  output logic [NPORT-1:0]       o_sop,
  output logic [NPORT-1:0]       o_eop,
  output logic                   o_clash,
  output logic                   o_mod_warn,
  output logic [ADDR_W-1:0]      o_port
);

  cyc_kind_e         evt_kind;
  logic              evt_addr;
  logic              evt_data;
  logic              evt_clash;
  logic [ADDR_W-1:0] evt_addr_port;
  logic [ADDR_W-1:0] cur_port;
  logic              evt_first;

  tx_cycle_decode #(.DW(DW), .ADDR_W(ADDR_W)) u_decode (
    .data      (i_data),
    .start     (i_start),
    .enable    (i_enable),
    .kind      (evt_kind),
    .is_addr   (evt_addr),
    .is_data   (evt_data),
    .is_clash  (evt_clash),
    .addr_port (evt_addr_port)
  );

  tx_port_track #(.NPORT(NPORT), .ADDR_W(ADDR_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .is_addr    (evt_addr),
    .addr_port  (evt_addr_port),
    .is_data    (evt_data),
    .eop        (i_eop),
    .cur_port   (cur_port),
    .first_word (evt_first)
  );

  tx_lane_steer #(
    .NPORT(NPORT), .DW(DW), .ADDR_W(ADDR_W), .BYTES(BYTES), .MOD_W(MOD_W)
  ) u_steer (
    .clk        (clk),
    .rst_n      (rst_n),
    .is_data    (evt_data),
    .is_clash   (evt_clash),
    .cur_port   (cur_port),
    .first_word (evt_first),
    .eop        (i_eop),
    .mod        (i_mod),
    .data       (i_data),
    .o_vld      (o_vld),
    .o_data     (o_data),
    .o_bmask    (o_bmask),
    .o_sop      (o_sop),
    .o_eop      (o_eop),
    .o_clash    (o_clash),
    .o_mod_warn (o_mod_warn)
  );

  always_comb o_port = cur_port;

  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(o_vld)); // R3

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_kind == CYC_IDLE) |=> ((o_vld == '0) && !o_clash && !o_mod_warn)); // R4

  AST_ADDR_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    evt_addr |=> (o_vld == '0)); // R2

  AST_CLASH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clash |=> (o_clash && (o_vld == '0) && $stable(o_port))); // R5

  AST_DATA_DELIVERED: assert property (@(posedge clk) disable iff (!rst_n)
    evt_data |=> ($countones(o_vld) == 1)); // R3

endmodule

// File: tb/sim_tx_inband_demux.sv
`timescale 1ns/1ps
module sim_tx_inband_demux;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  i_data = '0;
  logic         i_start = 1'b0;
  logic         i_enable = 1'b0;
  logic         i_eop = 1'b0;
  logic [1:0]   i_mod = '0;
  logic [3:0]   o_vld;
  logic [127:0] o_data;
  logic [15:0]  o_bmask;
  logic [3:0]   o_sop;
  logic [3:0]   o_eop;
  logic         o_clash;
  logic         o_mod_warn;
  logic [1:0]   o_port;

  int checks = 0;
  int errors = 0;

  int       m_port = 0;
  bit [3:0] m_open = '0;

  always #4 clk = ~clk;

  tx_inband_demux u0 (
    .clk(clk), .rst_n(rst_n), .i_data(i_data), .i_start(i_start),
    .i_enable(i_enable), .i_eop(i_eop), .i_mod(i_mod), .o_vld(o_vld),
    .o_data(o_data), .o_bmask(o_bmask), .o_sop(o_sop), .o_eop(o_eop),
    .o_clash(o_clash), .o_mod_warn(o_mod_warn), .o_port(o_port)
  );

  function automatic logic [3:0] ref_mask(input bit last, input logic [1:0] m);
    if (!last) return 4'b1111;
    case (m)
      2'd1:    return 4'b1000;
      2'd2:    return 4'b1100;
      2'd3:    return 4'b1110;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit s, input bit e, input bit last,
                      input logic [1:0] m, input logic [31:0] d, input string tag);
    logic [3:0]  x_vld;
    logic [3:0]  x_sop;
    logic [3:0]  x_eop;
    logic [3:0]  x_mask;
    bit          x_clash;
    bit          x_warn;
    int          p;
    @(negedge clk);
    i_start = s; i_enable = e; i_eop = last; i_mod = m; i_data = d;
    x_vld = '0; x_sop = '0; x_eop = '0; x_mask = '0; x_clash = 0; x_warn = 0;
    p = m_port;
    if (s && !e) begin
      m_port = int'(d[1:0]);
    end else if (!s && e) begin
      x_vld[p] = 1'b1;
      x_sop[p] = !m_open[p];
      x_eop[p] = last;
      x_mask   = ref_mask(last, m);
      x_warn   = !last && (m != 2'd0);
      m_open[p] = !last;
    end else if (s && e) begin
      x_clash = 1;
    end
    @(posedge clk);
    #1;
    chk({tag, " R3 vld"}, 32'(o_vld), 32'(x_vld));
    chk({tag, " R5 clash"}, 32'(o_clash), 32'(x_clash));
    chk({tag, " R7 warn"}, 32'(o_mod_warn), 32'(x_warn));
    chk({tag, " R2 port"}, 32'(o_port), 32'(m_port));
    if (x_vld != 0) begin
      chk({tag, " R3 data"}, o_data[p*32 +: 32], d);
      chk({tag, " R6 mask"}, 32'(o_bmask[p*4 +: 4]), 32'(x_mask));
      chk({tag, " R8 sop"}, 32'(o_sop), 32'(x_sop));
      chk({tag, " R10 eop"}, 32'(o_eop), 32'(x_eop));
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 vld", 32'(o_vld), 0);
    chk("R1 port", 32'(o_port), 0);
    chk("R1 flags", 32'({o_clash, o_mod_warn, o_sop, o_eop}), 0);
    chk("R1 data", o_data[31:0], 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: data before any address cycle lands on port 0
    step(0, 1, 0, 0, 32'hA0A0_0001, "R9 default");
    step(0, 1, 1, 2, 32'hA0A0_0002, "R9 tail");
    // R2: high bits of address word ignored
    step(1, 0, 0, 0, 32'hFFFF_FFF2, "R2 addr");
    step(0, 0, 1, 3, 32'h1234_5678, "R4 idle");
    step(0, 1, 0, 3, 32'hBEEF_0001, "R7 midwarn");
    step(1, 1, 0, 0, 32'h0000_0001, "R5 clash");
    for (int m = 0; m < 4; m++) begin
      step(0, 1, 1, 2'(m), 32'hC0DE_0000 + 32'(m), "R6 tail");
    end
    // R8: interleave port 1 packet around port 3 packet
    step(1, 0, 0, 0, 32'h1, "R8 a1");
    step(0, 1, 0, 0, 32'h1111_0001, "R8 p1w0");
    step(1, 0, 0, 0, 32'h3, "R8 a3");
    step(0, 1, 0, 0, 32'h3333_0001, "R8 p3w0");
    step(0, 1, 1, 1, 32'h3333_0002, "R8 p3end");
    step(1, 0, 0, 0, 32'h1, "R8 a1b");
    step(0, 1, 0, 0, 32'h1111_0002, "R8 p1w1");
    step(0, 1, 1, 0, 32'h1111_0003, "R8 p1end");

    for (int i = 0; i < 3000; i++) begin
      r = int'($urandom_range(0, 99));
      if (r < 20)
        step(1, 0, 0, 0, $urandom, "rnd addr");
      else if (r < 30)
        step(0, 0, 1'($urandom), 2'($urandom), $urandom, "rnd idle");
      else if (r < 35)
        step(1, 1, 1'($urandom), 2'($urandom), $urandom, "rnd clash");
      else
        step(0, 1, ($urandom_range(0, 9) == 0), 2'($urandom), $urandom, "rnd data");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule